// File: doc/BRIEF.md
# SCSI Controller Register and Interrupt Block

This block is the software-visible register file of a simple parallel SCSI interface controller. A processor reaches it over a 16-bit register bus with byte addresses that must be word aligned (multiples of 4). The block stores the controller's configuration: control/status, its own bus ID, the ID of the target to select, a data byte, the DMA timing mode, diagnostic words, and a few plain storage slots. It also keeps two status registers, one for the connection and one for the data transfer, and a command register whose bits start actions.

Three commands have modelled effects: select, disconnect and programmed-I/O transfer. Commands are evaluated in two situations: in the same clock edge that stores a new command word, and on every `tick` pulse. A tick also advances the three-bit bus phase field of the data-transfer status. Status flags are merged into a connection summary and a data summary. Both summaries read back in bits 15 and 14 of both status registers, and they drive a level interrupt gated by an enable bit. The physical bus, the DMA engine, arbitration and the reset-style commands are not modelled, and those command bits have no effect.

Top module: `scsi_regblk`

## Requirements
- R1: After a synchronous active-low reset every register reads 0 and `irq` is low.
- R2: Word offsets and write masks are: own ID 0x10 keeps bits [2:0]; selection target 0x14 keeps [2:0]; data 0x20 keeps [7:0]; DMA mode 0x24 keeps [1:0] (0 is asynchronous, nonzero is synchronous). Control/status 0x0C, diagnostic 0x00 and 0x54, and every other unassigned aligned offset store all 16 bits.
- R3: An access with address bits [1:0] not zero writes nothing and reads 0. The selection-detector status at 0x18 ignores writes and reads 0.
- R4: A write to connection status (0x48) clears each of bits 13, 12, 11, 9, 8, 7 that is written 1 and otherwise keeps them. Bits 6, 5, 4, 2, 1, 0 keep their value. Bit 10 takes the written value. Bit 3 becomes 0.
- R5: A write to data-transfer status (0x4C) clears bit 11, 10 or 4 where 1 is written and otherwise keeps them. Bits 2..0 keep their value. Bits 13 and 3 become 0. Bits 12, 9..5 take the written value.
- R6: Bit 14 of both status registers reads as the OR of data-transfer status bits 4, 10, 11 and 13. Bit 15 of both reads as the OR of connection status bits 7, 8, 9, 11, 12 and 13. Writes to bits 15..14 have no effect.
- R7: `irq` is high exactly when control/status bit 0 is 1 and either summary bit is 1.
- R8: Each `tick` pulse increments data-transfer status bits [2:0] modulo 8, ahead of that tick's command evaluation. Upper bits are unaffected.
- R9: Select (command bit 8), when evaluated, clears itself, sets connection status bit 2 (selection in progress) and clears bit 6 (connected).
- R10: Disconnect (command bit 10), evaluated before select, clears itself and connection status bits 6 and 2. It sets bit 7 (state change) only if bit 6 was 1.
- R11: Transfer (command bit 7) runs only if command bits [6:4] equal connection status bits [6:4], command bits [1:0] equal data-transfer status bits [1:0], and connection status bit 2 is 0. When it runs with command bit 15 (DMA) at 0, it clears command bit 7 and sets data-transfer status bit 11 (transmit buffer empty). With bit 15 at 1 it does nothing.
- R12: A write to the command register (0x50) stores the word with bit 14 forced to 0 and evaluates the commands in that same edge. Without a tick or a command write, pending command bits stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Internal tick pulse: phase count and command evaluation |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (7) | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from stored state |
| irq | output | 1 | Level interrupt |

## Verification
The transfer command is driven with the phase bits matching and then not matching the live phase. The mismatch case shows that the comparison really uses the tick-advanced phase count. The transfer is also issued with selection in progress, and together with a disconnect in the same command word. That last pattern separates the disconnect-before-transfer ordering from any other order, and a DMA-mode transfer shows the programmed-I/O path is the only one with an effect. Status writes with all ones and all zeros set apart the clear-on-one, keep and plain-write bit classes, and a pending transfer that only a tick completes separates tick-driven from write-driven evaluation.

// File: rtl/scsi_regblk_pkg.sv
// Package: slot indices, bit positions and write masks shared by the
// register block, its submodules and its checker.
package scsi_regblk_pkg;

    localparam int REG_W = 16;

    // Word slot indices (byte offset / 4)
    localparam int SLOT_CTRL    = 3;
    localparam int SLOT_OWNID   = 4;
    localparam int SLOT_TARGET  = 5;
    localparam int SLOT_DETECT  = 6;
    localparam int SLOT_DATA    = 8;
    localparam int SLOT_DMAMODE = 9;
    localparam int SLOT_CONN    = 18;
    localparam int SLOT_XFER    = 19;
    localparam int SLOT_CMD     = 20;

    // Status write classes (14 stored bits, 15..14 are summaries)
    localparam logic [13:0] CONN_CLR_MASK = 14'h3B88;
    localparam logic [13:0] CONN_KEEP_MASK = 14'h3BF7;
    localparam logic [13:0] XFER_CLR_MASK = 14'h2C18;
    localparam logic [13:0] XFER_KEEP_MASK = 14'h0C17;

    // Flags feeding the summaries
    localparam logic [13:0] CONN_SUM_MASK = 14'h3B80;
    localparam logic [13:0] XFER_SUM_MASK = 14'h2C10;

    // Connection status bits
    localparam int CONN_SCHG = 7;
    localparam int CONN_LINK = 6;
    localparam int CONN_SELP = 2;

    // Data-transfer status bits
    localparam int XFER_TXE = 11;

    // Command bits
    localparam int CMD_DMA   = 15;
    localparam int CMD_RST   = 14;
    localparam int CMD_DROP  = 10;
    localparam int CMD_SEL   = 8;
    localparam int CMD_MOVE  = 7;

    // Storage mask of a plain slot; 0 means the slot is not stored here.
    function automatic logic [REG_W-1:0] slot_mask(input int idx);
        case (idx)
            SLOT_OWNID, SLOT_TARGET:           return 16'h0007;
            SLOT_DATA:                         return 16'h00FF;
            SLOT_DMAMODE:                      return 16'h0003;
            SLOT_DETECT, SLOT_CONN, SLOT_XFER,
            SLOT_CMD:                          return 16'h0000;
            default:                           return 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/scsi_reg_store.sv
// Plain register storage: one slot per aligned word offset.
// Assumes at most one write per cycle; each slot keeps only the bits of
// its mask, and a slot with an all-zero mask is a constant zero.
module scsi_reg_store
    import scsi_regblk_pkg::*;
#(
    parameter int NSLOT  = 32,
    parameter int SLOT_W = $clog2(NSLOT)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SLOT_W-1:0]             wr_slot,
    input  logic [REG_W-1:0]              wr_data,
    output logic [NSLOT-1:0][REG_W-1:0]   slots_q
);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        localparam logic [REG_W-1:0] MASK = slot_mask(i);
        if (MASK == '0) begin : g_const
            // Slot owned elsewhere or read-only: reads as zero here
            assign slots_q[i] = '0;
        end else begin : g_reg
            // Store masked write data for this slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slots_q[i] <= '0;
                else if (wr_en && (wr_slot == SLOT_W'(i)))
                    slots_q[i] <= wr_data & MASK;
            end
        end
    end

endmodule

// File: rtl/scsi_status_engine.sv
// Connection status, data-transfer status and command register, with the
// command effects. Write merging comes first, then the tick phase count,
// then (on tick or command write) disconnect, select and transfer in order.
// Assumes at most one of the three write strobes is active per cycle.
module scsi_status_engine
    import scsi_regblk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              conn_wr,
    input  logic              xfer_wr,
    input  logic              cmd_wr,
    input  logic [REG_W-1:0]  wdata,
    output logic [13:0]       conn_q,
    output logic [13:0]       xfer_q,
    output logic [REG_W-1:0]  cmd_q
);

    logic [13:0]      conn_d, xfer_d;
    logic [REG_W-1:0] cmd_d;
    logic             eval;

    assign eval = tick || cmd_wr;

    // Next-state of the three registers, applied in a fixed order
    always_comb begin
        conn_d = conn_q;
        xfer_d = xfer_q;
        cmd_d  = cmd_q;
        if (conn_wr)
            conn_d = ((conn_q & ~(wdata[13:0] & CONN_CLR_MASK)) & CONN_KEEP_MASK)
                   | (wdata[13:0] & ~CONN_CLR_MASK & ~CONN_KEEP_MASK);
        if (xfer_wr)
            xfer_d = ((xfer_q & ~(wdata[13:0] & XFER_CLR_MASK)) & XFER_KEEP_MASK)
                   | (wdata[13:0] & ~XFER_CLR_MASK & ~XFER_KEEP_MASK);
        if (cmd_wr) begin
            cmd_d = wdata;
            cmd_d[CMD_RST] = 1'b0;
        end
        if (tick)
            xfer_d[2:0] = xfer_d[2:0] + 3'd1;
        if (eval) begin
            if (cmd_d[CMD_DROP]) begin
                if (conn_d[CONN_LINK])
                    conn_d[CONN_SCHG] = 1'b1;
                conn_d[CONN_LINK] = 1'b0;
                conn_d[CONN_SELP] = 1'b0;
                cmd_d[CMD_DROP]   = 1'b0;
            end
            if (cmd_d[CMD_SEL]) begin
                cmd_d[CMD_SEL]    = 1'b0;
                conn_d[CONN_SELP] = 1'b1;
                conn_d[CONN_LINK] = 1'b0;
            end
            if (cmd_d[CMD_MOVE] && (cmd_d[6:4] == conn_d[6:4]) &&
                (cmd_d[1:0] == xfer_d[1:0]) && !conn_d[CONN_SELP] &&
                !cmd_d[CMD_DMA]) begin
                cmd_d[CMD_MOVE]  = 1'b0;
                xfer_d[XFER_TXE] = 1'b1;
            end
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn_q <= '0;
            xfer_q <= '0;
            cmd_q  <= '0;
        end else begin
            conn_q <= conn_d;
            xfer_q <= xfer_d;
            cmd_q  <= cmd_d;
        end
    end

endmodule

// File: rtl/scsi_irq_merge.sv
// Summary flags and interrupt. Purely combinational from stored status;
// assumes the status inputs come straight from registers.
module scsi_irq_merge
    import scsi_regblk_pkg::*;
(
    input  logic [13:0] conn_q,
    input  logic [13:0] xfer_q,
    input  logic        irq_en,
    output logic        conn_sum,
    output logic        xfer_sum,
    output logic        irq
);

    // OR-reduce the flags of each status register and gate with enable
    always_comb begin
        conn_sum = |(conn_q & CONN_SUM_MASK);
        xfer_sum = |(xfer_q & XFER_SUM_MASK);
        irq      = irq_en && (conn_sum || xfer_sum);
    end

endmodule

// File: rtl/scsi_regblk.sv
// Top of the SCSI controller register block. Decodes aligned word accesses,
// routes writes to plain storage or the status engine, and muxes read data
// (combinational, same cycle). Misaligned accesses are dropped.
module scsi_regblk
    import scsi_regblk_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq
);

    localparam int SLOT_W = ADDR_W - 2;
    localparam int NSLOT  = 1 << SLOT_W;

    logic                        acc_ok, wr_ok;
    logic [SLOT_W-1:0]           slot;
    logic                        conn_wr, xfer_wr, cmd_wr;
    logic [NSLOT-1:0][REG_W-1:0] slots_q;
    logic [13:0]                 conn_q, xfer_q;
    logic [REG_W-1:0]            cmd_q;
    logic                        conn_sum, xfer_sum;
    logic                        csr_ie;

    // Address decode
    always_comb begin
        acc_ok  = bus_sel && (bus_addr[1:0] == 2'b00);
        wr_ok   = acc_ok && bus_wr;
        slot    = bus_addr[ADDR_W-1:2];
        conn_wr = wr_ok && (slot == SLOT_W'(SLOT_CONN));
        xfer_wr = wr_ok && (slot == SLOT_W'(SLOT_XFER));
        cmd_wr  = wr_ok && (slot == SLOT_W'(SLOT_CMD));
    end

    scsi_reg_store #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_slot (slot),
        .wr_data (bus_wdata),
        .slots_q (slots_q)
    );

    scsi_status_engine u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .conn_wr (conn_wr),
        .xfer_wr (xfer_wr),
        .cmd_wr  (cmd_wr),
        .wdata   (bus_wdata),
        .conn_q  (conn_q),
        .xfer_q  (xfer_q),
        .cmd_q   (cmd_q)
    );

    assign csr_ie = slots_q[SLOT_CTRL][0];

    scsi_irq_merge u_merge (
        .conn_q   (conn_q),
        .xfer_q   (xfer_q),
        .irq_en   (csr_ie),
        .conn_sum (conn_sum),
        .xfer_sum (xfer_sum),
        .irq      (irq)
    );

    // Read mux: status words carry both summaries in bits 15..14
    always_comb begin
        if (!acc_ok)
            bus_rdata = '0;
        else if (slot == SLOT_W'(SLOT_CONN))
            bus_rdata = {conn_sum, xfer_sum, conn_q};
        else if (slot == SLOT_W'(SLOT_XFER))
            bus_rdata = {conn_sum, xfer_sum, xfer_q};
        else if (slot == SLOT_W'(SLOT_CMD))
            bus_rdata = cmd_q;
        else
            bus_rdata = slots_q[slot];
    end

endmodule

// File: rtl/scsi_regblk_chk.sv
// Checker for scsi_regblk: relates command writes, ticks, stored status
// and the interrupt output over time. Attached by bind below.
module scsi_regblk_chk
    import scsi_regblk_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              cmd_wr,
    input logic              csr_ie,
    input logic [13:0]       conn_q,
    input logic [13:0]       xfer_q,
    input logic [REG_W-1:0]  cmd_q,
    input logic              irq
);

    a_r8_phase_count: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> xfer_q[2:0] == 3'($past(xfer_q[2:0]) + 3'd1));

    a_r9_select: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[CMD_SEL]) |=>
            (conn_q[CONN_SELP] && !conn_q[CONN_LINK] && !cmd_q[CMD_SEL]));

    a_r10_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[CMD_DROP] && !bus_wdata[CMD_SEL]) |=>
            (!conn_q[CONN_SELP] && !conn_q[CONN_LINK] && !cmd_q[CMD_DROP]));

    a_r11_dma_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[CMD_DMA] && bus_wdata[CMD_MOVE]) |=> cmd_q[CMD_MOVE]);

    a_r7_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (csr_ie && ((|(conn_q & CONN_SUM_MASK)) || (|(xfer_q & XFER_SUM_MASK)))));

    a_r3_detect_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == ADDR_W'(SLOT_DETECT * 4))) |-> bus_rdata == '0);

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cmd_wr) |=> $stable(cmd_q));

endmodule

bind scsi_regblk scsi_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cmd_wr    (cmd_wr),
    .csr_ie    (csr_ie),
    .conn_q    (conn_q),
    .xfer_q    (xfer_q),
    .cmd_q     (cmd_q),
    .irq       (irq)
);

// File: tb/scsi_regblk_tb.sv
// Directed bench for scsi_regblk: one task per scenario, each checking
// its own results at the falling edge after the updating rising edge.
module scsi_regblk_tb;

    localparam int ADDR_W = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic              irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    scsi_regblk #(.ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        rd(7'h0C, v); check("R1 ctrl", v, 16'h0);
        rd(7'h48, v); check("R1 conn", v, 16'h0);
        rd(7'h4C, v); check("R1 xfer", v, 16'h0);
        rd(7'h50, v); check("R1 cmd", v, 16'h0);
        check("R1 irq", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_masks();
        logic [15:0] v;
        do_reset();
        wr(7'h10, 16'hFFFF); rd(7'h10, v); check("R2 own id", v, 16'h0007);
        wr(7'h14, 16'hABCD); rd(7'h14, v); check("R2 target", v, 16'h0005);
        wr(7'h20, 16'h1234); rd(7'h20, v); check("R2 data", v, 16'h0034);
        wr(7'h24, 16'hFFFF); rd(7'h24, v); check("R2 dma mode", v, 16'h0003);
        wr(7'h54, 16'h5A5A); rd(7'h54, v); check("R2 diag ctl", v, 16'h5A5A);
        wr(7'h40, 16'hC3C3); rd(7'h40, v); check("R2 spare slot", v, 16'hC3C3);
    endtask

    task automatic t_ignored();
        logic [15:0] v;
        do_reset();
        wr(7'h10, 16'h0003);
        wr(7'h11, 16'h0006); rd(7'h10, v); check("R3 misaligned write", v, 16'h0003);
        rd(7'h12, v); check("R3 misaligned read", v, 16'h0);
        wr(7'h18, 16'hFFFF); rd(7'h18, v); check("R3 detector ro", v, 16'h0);
    endtask

    task automatic t_status_writes();
        logic [15:0] v;
        do_reset();
        wr(7'h50, 16'h0100);
        wr(7'h48, 16'hFFFF); rd(7'h48, v); check("R4 conn ones", v, 16'h0404);
        wr(7'h48, 16'h0000); rd(7'h48, v); check("R4 conn zeros", v, 16'h0004);
        wr(7'h4C, 16'hFFFF); rd(7'h4C, v); check("R5 xfer ones", v, 16'h13E0);
        wr(7'h4C, 16'h0000); rd(7'h4C, v); check("R5 xfer zeros", v, 16'h0000);
    endtask

    task automatic t_phase_tick();
        logic [15:0] v;
        do_reset();
        for (int i = 0; i < 9; i++) pulse_tick();
        rd(7'h4C, v); check("R8 phase wrap", v, 16'h0001);
        wr(7'h4C, 16'h0006); rd(7'h4C, v); check("R8 phase kept on write", v, 16'h0001);
    endtask

    task automatic t_select_disconnect();
        logic [15:0] v;
        do_reset();
        wr(7'h50, 16'h0100);
        rd(7'h50, v); check("R9 select clears", v, 16'h0);
        rd(7'h48, v); check("R9 sel in progress", v, 16'h0004);
        wr(7'h50, 16'h0400);
        rd(7'h50, v); check("R10 disconnect clears", v, 16'h0);
        rd(7'h48, v); check("R10 no state change", v, 16'h0);
    endtask

    task automatic t_transfer_irq();
        logic [15:0] v;
        do_reset();
        wr(7'h50, 16'h0080);
        rd(7'h50, v); check("R11 transfer done", v, 16'h0);
        rd(7'h4C, v); check("R6 xfer summary", v, 16'h4800);
        rd(7'h48, v); check("R6 conn mirror", v, 16'h4000);
        check("R7 irq masked", {15'h0, irq}, 16'h0);
        wr(7'h0C, 16'h0001);
        check("R7 irq on", {15'h0, irq}, 16'h1);
        wr(7'h4C, 16'h0800);
        rd(7'h4C, v); check("R5 txe cleared", v, 16'h0);
        check("R7 irq off", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_transfer_gates();
        logic [15:0] v;
        do_reset();
        pulse_tick();
        wr(7'h50, 16'h0080); rd(7'h50, v); check("R11 phase mismatch", v, 16'h0080);
        wr(7'h50, 16'h0081); rd(7'h50, v); check("R11 phase match", v, 16'h0001);
        rd(7'h4C, v); check("R11 txe set", v, 16'h4801);
        do_reset();
        wr(7'h50, 16'h0100);
        wr(7'h50, 16'h0080); rd(7'h50, v); check("R11 blocked by selection", v, 16'h0080);
        wr(7'h50, 16'h0480); rd(7'h50, v); check("R10 disconnect before transfer", v, 16'h0);
        rd(7'h48, v); check("R10 sel cleared", v, 16'h4000);
        do_reset();
        wr(7'h50, 16'h8080); rd(7'h50, v); check("R11 dma no effect", v, 16'h8080);
        rd(7'h4C, v); check("R11 dma no txe", v, 16'h0);
    endtask

    task automatic t_command_write();
        logic [15:0] v;
        do_reset();
        wr(7'h50, 16'h4000); rd(7'h50, v); check("R12 reset bit dropped", v, 16'h0);
        wr(7'h50, 16'h0081);
        repeat (3) @(negedge clk);
        rd(7'h50, v); check("R12 pending without tick", v, 16'h0081);
        pulse_tick();
        rd(7'h50, v); check("R12 tick evaluates", v, 16'h0001);
        rd(7'h4C, v); check("R8 tick then transfer", v, 16'h4801);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_masks();
        t_ignored();
        t_status_writes();
        t_phase_tick();
        t_select_disconnect();
        t_transfer_irq();
        t_transfer_gates();
        t_command_write();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule